// File: doc/BRIEF.md
# Non-posted credit gated request queue

This block sits on the delivery side of a completer request stream. Requests come in on a valid/ready stream. Each request carries a flag that marks it as posted (a write) or non-posted (a read). The block keeps the two classes in separate buffers and records how old each non-posted entry is compared with the posted entries. It then offers requests on a valid/ready output stream.

The consumer downstream hands out non-posted credits through a two-bit grant input. A counter tracks these credits and is visible on an output port. A non-posted request may leave only while the counter is above zero. When the counter is at zero, a posted request that arrived later may overtake the waiting non-posted ones. While credits are available, requests leave in arrival order. Once a request is offered, it stays on the output unchanged until the consumer accepts it.

Top module: `np_credit_queue`

## Requirements
- R1: After reset the credit counter is zero, the overflow flag is low and no request is offered.
- R2: Each non-posted request accepted on the output stream lowers the credit counter by one.
- R3: The grant input adds credits as follows: 2'b00 adds none, 2'b01 adds one, 2'b10 adds two, and 2'b11 also adds two.
- R4: A grant and a non-posted transfer in the same cycle are applied together as one net change to the counter.
- R5: The counter never exceeds 32. Credits that would take it above 32 are dropped, and they set an overflow flag that stays high until reset.
- R6: While the counter is zero, no non-posted request is offered.
- R7: While the counter is zero and a posted request is buffered, the oldest posted request is offered, even if older non-posted requests are waiting.
- R8: While the counter is above zero, the oldest buffered request of either class is offered.
- R9: Posted requests leave in their arrival order, and so do non-posted requests.
- R10: An offered request (valid, type flag and data) stays unchanged until out_ready is seen, even if credits arrive in the meantime.
- R11: Each class has its own buffer of 8 entries. in_ready is high exactly when the buffer for the class given by in_np is not full, counted before this cycle's departures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input request valid |
| in_ready | output | 1 | Input request accepted when high with in_valid |
| in_np | input | 1 | 1 = non-posted request, 0 = posted request |
| in_data | input | 32 | Input request payload |
| out_valid | output | 1 | Output request valid |
| out_ready | input | 1 | Consumer accepts the output request |
| out_np | output | 1 | Type flag of the offered request |
| out_data | output | 32 | Payload of the offered request |
| np_grant | input | 2 | Credit grant from the consumer |
| credit_cnt | output | 6 | Current non-posted credit count |
| credit_ovf | output | 1 | Sticky flag: a grant was dropped at saturation |

## Verification
The hardest case to reach is this one. A posted request is offered because the counter is zero and an older non-posted request is waiting. The consumer stalls, and a grant arrives during the stall. The design must keep the posted request on the output and must not switch to the non-posted one. One stimulus phase fills the queue with non-posted traffic while no credits are granted. It then mixes in posted requests, drives out_ready low most of the time and grants credits only now and then, so this situation comes up many times. A second phase drives mostly 2'b10 and 2'b11 grants with little traffic, which pushes the counter to saturation and sets the overflow flag.

// File: rtl/npq_pkg.sv
package npq_pkg;

  // Credit value carried by one grant code. 2'b11 counts the same as 2'b10.
  function automatic logic [1:0] grant_value(input logic [1:0] code);
    logic [1:0] v;
    case (code)
      2'b00:   v = 2'd0;
      2'b01:   v = 2'd1;
      default: v = 2'd2;
    endcase
    return v;
  endfunction

  // Unclamped next count: current + grant - issue. Result is one bit wider than the counter.
  function automatic logic [7:0] credit_sum(input logic [6:0] cur,
                                            input logic [1:0] code,
                                            input logic       issue);
    logic [7:0] s;
    s = {1'b0, cur} + {6'd0, grant_value(code)} - {7'd0, issue};
    return s;
  endfunction

endpackage

// File: rtl/npq_fifo.sv
module npq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign dout = mem[rd_ptr];

  // R11
  posted_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CW'(DEPTH)));

  // R9
  posted_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

endmodule

// File: rtl/npq_np_fifo.sv
module npq_np_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int AHW   = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [W-1:0]   din,
  input  logic [AHW-1:0] stamp,
  input  logic           pop,
  input  logic           posted_left,
  output logic [W-1:0]   dout,
  output logic [AHW-1:0] head_ahead,
  output logic [CW-1:0]  count
);

  logic [W-1:0]   mem   [DEPTH];
  logic [AHW-1:0] ahead [DEPTH];
  logic [AW-1:0]  rd_ptr, wr_ptr;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // Per-slot count of older posted requests still buffered
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ahead[i] <= '0;
      end else if (push && wr_ptr == AW'(i)) begin
        ahead[i] <= stamp;
      end else if (posted_left && ahead[i] != '0) begin
        ahead[i] <= ahead[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign dout       = mem[rd_ptr];
  assign head_ahead = ahead[rd_ptr];

  // R11
  np_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CW'(DEPTH)));

  // R9
  np_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

endmodule

// File: rtl/npq_credit_ctr.sv
module npq_credit_ctr
  import npq_pkg::*;
#(
  parameter int CRED_MAX = 32,
  localparam int CW      = $clog2(CRED_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    grant,
  input  logic          issue,
  output logic [CW-1:0] count,
  output logic          ovf
);

  logic [7:0] sum;
  logic       over;

  assign sum  = credit_sum(7'(count), grant, issue);
  assign over = (sum > 8'(CRED_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= over ? CW'(CRED_MAX) : CW'(sum);
      if (over) ovf <= 1'b1;
    end
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(CRED_MAX));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R2
  issue_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && grant == 2'b00) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/npq_arbiter.sv
module npq_arbiter #(
  parameter int AHW = 4,
  parameter int CW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           p_avail,
  input  logic           n_avail,
  input  logic [AHW-1:0] n_ahead,
  input  logic [CW-1:0]  credits,
  input  logic           out_ready,
  output logic           out_valid,
  output logic           sel_np
);

  logic held_v, held_np;
  logic nat_np, nat_p;

  // Non-posted wins only when it is the oldest and a credit is available
  assign nat_np = n_avail && (credits != '0) && (n_ahead == '0);
  assign nat_p  = p_avail && !nat_np;

  assign out_valid = held_v || nat_np || nat_p;
  assign sel_np    = held_v ? held_np : nat_np;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v  <= 1'b0;
      held_np <= 1'b0;
    end else begin
      held_v  <= out_valid && !out_ready;
      held_np <= sel_np;
    end
  end

  // R6
  np_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel_np) |-> (credits != '0));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(sel_np)));

endmodule

// File: rtl/np_credit_queue.sv
module np_credit_queue
  import npq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int P_DEPTH  = 8,
  parameter int N_DEPTH  = 8,
  parameter int CRED_MAX = 32,
  localparam int PCW     = $clog2(P_DEPTH + 1),
  localparam int NCW     = $clog2(N_DEPTH + 1),
  localparam int CW      = $clog2(CRED_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_np,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_np,
  output logic [DATA_W-1:0] out_data,
  input  logic [1:0]        np_grant,
  output logic [CW-1:0]     credit_cnt,
  output logic              credit_ovf
);

  logic [PCW-1:0]    p_count;
  logic [NCW-1:0]    n_count;
  logic [DATA_W-1:0] p_head, n_head;
  logic [PCW-1:0]    n_ahead;
  logic              p_push, n_push, p_pop, n_pop, out_fire;
  logic [PCW-1:0]    stamp;

  assign in_ready = in_np ? (n_count != NCW'(N_DEPTH)) : (p_count != PCW'(P_DEPTH));
  assign p_push   = in_valid && in_ready && !in_np;
  assign n_push   = in_valid && in_ready && in_np;
  assign out_fire = out_valid && out_ready;
  assign n_pop    = out_fire && out_np;
  assign p_pop    = out_fire && !out_np;
  // Posted entries older than a new non-posted entry, after this cycle's departure
  assign stamp    = p_count - PCW'(p_pop);

  npq_fifo #(.W(DATA_W), .DEPTH(P_DEPTH)) i_pfifo (
    .clk(clk), .rst_n(rst_n), .push(p_push), .din(in_data),
    .pop(p_pop), .dout(p_head), .count(p_count));

  npq_np_fifo #(.W(DATA_W), .DEPTH(N_DEPTH), .AHW(PCW)) i_nfifo (
    .clk(clk), .rst_n(rst_n), .push(n_push), .din(in_data), .stamp(stamp),
    .pop(n_pop), .posted_left(p_pop), .dout(n_head), .head_ahead(n_ahead),
    .count(n_count));

  npq_credit_ctr #(.CRED_MAX(CRED_MAX)) i_cred (
    .clk(clk), .rst_n(rst_n), .grant(np_grant), .issue(n_pop),
    .count(credit_cnt), .ovf(credit_ovf));

  npq_arbiter #(.AHW(PCW), .CW(CW)) i_arb (
    .clk(clk), .rst_n(rst_n), .p_avail(p_count != '0), .n_avail(n_count != '0),
    .n_ahead(n_ahead), .credits(credit_cnt), .out_ready(out_ready),
    .out_valid(out_valid), .sel_np(out_np));

  assign out_data = out_np ? n_head : p_head;

  // R10
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  // R7
  posted_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_cnt == '0 && p_count != '0) |-> (out_valid && !out_np));

endmodule

// File: tb/test_np_credit_queue.sv
module test_np_credit_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int CMAX       = 32;

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_np = 0, out_ready = 0;
  logic [31:0] in_data = 0;
  logic [1:0]  np_grant = 0;
  logic        in_ready, out_valid, out_np, credit_ovf;
  logic [31:0] out_data;
  logic [5:0]  credit_cnt;

  np_credit_queue i_np_credit_queue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_np(in_np), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_np(out_np), .out_data(out_data), .np_grant(np_grant),
    .credit_cnt(credit_cnt), .credit_ovf(credit_ovf));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { bit np; logic [31:0] d; int seq; } req_t;
  req_t q[$];
  int   m_cred = 0;
  bit   m_ovf = 0;
  bit   m_held = 0;
  int   held_seq = 0;
  int   next_seq = 0;
  int   n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int count_cls(input bit np);
    int c = 0;
    foreach (q[i]) if (q[i].np == np) c++;
    return c;
  endfunction

  // Index of the request that should be on the output, or -1
  function automatic int pick();
    if (m_held) begin
      foreach (q[i]) if (q[i].seq == held_seq) return i;
      return -1;
    end
    if (q.size() == 0) return -1;
    if (!q[0].np || m_cred > 0) return 0;
    foreach (q[i]) if (!q[i].np) return i;
    return -1;
  endfunction

  function automatic int gval(input logic [1:0] g);
    return (g == 2'b00) ? 0 : (g == 2'b01) ? 1 : 2;
  endfunction

  // One cycle: drive at negedge, compare, advance the model
  task automatic step(input int p_in, input int p_np, input int p_rdy, input int p_gr, input bit g_hi);
    int  idx;
    bit  exp_rdy, ofire, ifire;
    int  sum;
    @(negedge clk);
    in_valid  = ($urandom_range(99) < p_in);
    in_np     = ($urandom_range(99) < p_np);
    in_data   = $urandom;
    out_ready = ($urandom_range(99) < p_rdy);
    if ($urandom_range(99) < p_gr) np_grant = g_hi ? 2'($urandom_range(3, 2)) : 2'($urandom_range(3, 1));
    else np_grant = 2'b00;
    #1;
    idx     = pick();
    exp_rdy = (count_cls(in_np) < DEPTH);
    chk("R11", "in_ready", 32'(in_ready), 32'(exp_rdy));
    chk("R6/R7", "out_valid", 32'(out_valid), 32'(idx >= 0));
    if (idx >= 0) begin
      chk("R8/R9/R10", "out_np", 32'(out_np), 32'(q[idx].np));
      chk("R8/R9/R10", "out_data", out_data, q[idx].d);
    end
    chk("R2/R3/R4", "credit_cnt", 32'(credit_cnt), 32'(m_cred));
    chk("R5", "credit_ovf", 32'(credit_ovf), 32'(m_ovf));
    // advance model
    ofire = (idx >= 0) && out_ready;
    ifire = in_valid && exp_rdy;
    sum = m_cred + gval(np_grant) - ((ofire && q[idx].np) ? 1 : 0);
    if (sum > CMAX) begin sum = CMAX; m_ovf = 1; end
    m_cred = sum;
    m_held = (idx >= 0) && !out_ready;
    if (idx >= 0) held_seq = q[idx].seq;
    if (ofire) q.delete(idx);
    if (ifire) begin
      q.push_back('{np: in_np, d: in_data, seq: next_seq});
      next_seq++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R1: reset state
    chk("R1", "credit_cnt", 32'(credit_cnt), 0);
    chk("R1", "credit_ovf", 32'(credit_ovf), 0);
    chk("R1", "out_valid", 32'(out_valid), 0);
    @(negedge clk);
    rst_n = 1;
    // No credits: non-posted blocked, posted overtake (R6, R7)
    for (int i = 0; i < 300; i++) step(60, 70, 70, 0, 0);
    // Mixed traffic with credits, arrival order (R8, R9, R2, R3, R4)
    for (int i = 0; i < 800; i++) step(60, 50, 60, 20, 0);
    // Starved credits with stalls, grants arriving while a posted request is held (R10)
    for (int i = 0; i < 800; i++) step(50, 60, 20, 8, 0);
    // Credit draining to zero then overtaking (R7)
    for (int i = 0; i < 400; i++) step(70, 50, 80, 3, 0);
    // Saturation with large grants (R5)
    for (int i = 0; i < 200; i++) step(10, 90, 30, 90, 1);
    // Drain everything (R9)
    for (int i = 0; i < 300; i++) step(0, 50, 90, 30, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule